// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable integer N and emits a one-cycle pulse toward a phase detector once every N input cycles. A dual-modulus prescaler divides by either P or P+1, and its output events drive two down-counters. The swallow counter keeps the prescaler at P+1 for its first A events. The main counter then lets the cycle finish at P until B events have elapsed in total. The resulting ratio is N = B·P + A. The prescaler pair is selectable among 8/9, 16/17, 32/33 and 64/65. It is built from a synchronous divide-by-4/5 core followed by a binary extension stage.

The three settings (prescaler select, A and B) are captured only at reset and at the terminal count of a division cycle, so a cycle in progress is never disturbed. An A larger than B, or a B below the legal minimum of 3, is corrected before use and raises a configuration-error flag. The flag covers the division cycle that used those settings.

Top module: `swallow_divider`

## Requirements
- R1: With legal settings, consecutive output pulses are exactly N = B·P + A input cycles apart. The prescaler runs at P+1 for the first A of its output events in each cycle and at P for the rest.
- R2: The 2-bit prescaler select maps 0, 1, 2 and 3 to a lower modulus P of 8, 16, 32 and 64 respectively.
- R3: With A = 0, the period is exactly B·P input cycles.
- R4: When A > B, A is replaced by B, so N = B·(P+1). cfg_err reads 1 for that division cycle, and 0 for a cycle whose settings are legal.
- R5: A B value below 3 is treated as 3, with A clamped against that value, and cfg_err reads 1.
- R6: Changes to p_sel, a_in or b_in during a division cycle do not alter that cycle's length or the cfg_err flag. They take effect from the cycle that starts after the next output pulse.
- R7: fb_pulse is high for exactly one input cycle per division cycle.
- R8: rst is synchronous. It loads the current settings, and while it is held fb_pulse is low. Counting the first cycle after rst falls as cycle 1, fb_pulse first rises in cycle N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high; also loads the settings |
| p_sel | input | 2 | Prescaler pair select (0:8/9, 1:16/17, 2:32/33, 3:64/65) |
| a_in | input | 6 | Swallow count A |
| b_in | input | 13 | Main count B |
| fb_pulse | output | 1 | One-cycle pulse every N input cycles |
| cfg_err | output | 1 | Settings in use were out of range and were corrected |

## Verification
The hardest case to reach from the ports is a settings change that arrives in the middle of a running division cycle. The old cycle must finish unchanged and the new ratio must apply only from the following pulse. The bench waits for a pulse, lets a few cycles pass, and then drives new values. It checks that the remaining count matches the old N and the next full period matches the new N. It repeats this with an A > B setting, so that the error flag is also seen to wait for the boundary. The table of vectors covers every prescaler select, A = 0, A = B, A > B and B below its minimum.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  localparam int SEL_W = 2;
  localparam int A_W   = 6;
  localparam int B_W   = 13;
  localparam int B_MIN = 3;
  localparam int EXT_W = 4;   // extension stage counts up to 16 core cycles
  localparam int CORE_W = 3;  // 4/5 core state 0..4
  localparam int LEN_W = 7;   // fits P+1 = 65

  // lower modulus P for a select code
  function automatic logic [LEN_W-1:0] p_of(logic [SEL_W-1:0] sel);
    return LEN_W'(32'd8 << sel);
  endfunction

  // last index of the extension stage (core cycles per prescaler cycle, minus 1)
  function automatic logic [EXT_W-1:0] ext_last(logic [SEL_W-1:0] sel);
    return EXT_W'((32'd2 << sel) - 32'd1);
  endfunction

  function automatic logic [B_W-1:0] b_legal(logic [B_W-1:0] b);
    return (b < B_W'(B_MIN)) ? B_W'(B_MIN) : b;
  endfunction

  function automatic logic [A_W-1:0] a_legal(logic [A_W-1:0] a, logic [B_W-1:0] b);
    logic [B_W-1:0] bl;
    bl = b_legal(b);
    return (B_W'(a) > bl) ? A_W'(bl) : a;
  endfunction

  function automatic logic cfg_bad(logic [A_W-1:0] a, logic [B_W-1:0] b);
    return (b < B_W'(B_MIN)) || (B_W'(a) > b_legal(b));
  endfunction
endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
  import swdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             mod_hi,
  output logic             tick
);
  logic [CORE_W-1:0] core_q;
  logic [EXT_W-1:0]  ext_q;
  logic              last_core;
  logic [CORE_W-1:0] core_top;
  logic              core_wrap;

  assign last_core = (ext_q == ext_last(sel));
  // the 4/5 core stretches to five cycles once per prescaler cycle when mod_hi
  assign core_top  = (last_core && mod_hi) ? CORE_W'(4) : CORE_W'(3);
  assign core_wrap = (core_q == core_top);
  assign tick      = core_wrap && last_core;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_q <= '0;
      ext_q  <= '0;
    end else begin
      core_q <= core_wrap ? '0 : core_q + CORE_W'(1);
      if (core_wrap) ext_q <= last_core ? '0 : ext_q + EXT_W'(1);
    end
  end

  // length counter for checking only
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk) begin
    if (rst || tick) len_q <= '0;
    else             len_q <= len_q + LEN_W'(1);
  end

  p_len_r2: assert property (@(posedge clk) disable iff (rst)
    tick |-> (len_q + LEN_W'(1) == p_of(sel) + LEN_W'(mod_hi)));
  p_core_bound_r2: assert property (@(posedge clk) disable iff (rst)
    core_q <= CORE_W'(4));
  p_ext_bound_r2: assert property (@(posedge clk) disable iff (rst)
    ext_q <= ext_last(sel));
endmodule

// File: rtl/swdiv_counters.sv
module swdiv_counters
  import swdiv_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [A_W-1:0] a_load,
  input  logic [B_W-1:0] b_load,
  output logic           mod_hi,
  output logic           term
);
  logic [A_W-1:0] a_rem;
  logic [B_W-1:0] b_rem;

  assign mod_hi = (a_rem != '0);
  assign term   = tick && (b_rem == B_W'(1));

  always_ff @(posedge clk) begin
    if (rst || term) begin
      a_rem <= a_load;
      b_rem <= b_load;
    end else if (tick) begin
      b_rem <= b_rem - B_W'(1);
      if (a_rem != '0) a_rem <= a_rem - A_W'(1);
    end
  end

  // swallow phase always precedes the main phase within a cycle
  p_swallow_first_r1: assert property (@(posedge clk) disable iff (rst)
    (!mod_hi && !term) |=> !mod_hi);
  // clamped swallow count never exceeds the remaining main count
  p_a_within_b_r4: assert property (@(posedge clk) disable iff (rst)
    B_W'(a_rem) <= b_rem);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] p_sel,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  output logic             fb_pulse,
  output logic             cfg_err
);
  logic [SEL_W-1:0] sel_q;
  logic             tick;
  logic             mod_hi;
  logic             term;
  logic [A_W-1:0]   a_eff;
  logic [B_W-1:0]   b_eff;

  assign b_eff = b_legal(b_in);
  assign a_eff = a_legal(a_in, b_in);

  always_ff @(posedge clk) begin
    if (rst || term) begin
      sel_q   <= p_sel;
      cfg_err <= cfg_bad(a_in, b_in);
    end
  end

  swdiv_prescaler u_pre (
    .clk(clk), .rst(rst), .sel(sel_q), .mod_hi(mod_hi), .tick(tick)
  );

  swdiv_counters u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .a_load(a_eff), .b_load(b_eff),
    .mod_hi(mod_hi), .term(term)
  );

  assign fb_pulse = term;

  p_mc_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(mod_hi));
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !term |=> ($stable(sel_q) && $stable(cfg_err)));
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse);
endmodule

// File: tb/tb_swallow_divider.sv
module tb_swallow_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  p_sel = '0;
  logic [5:0]  a_in = '0;
  logic [12:0] b_in = 13'd3;
  logic        fb_pulse;
  logic        cfg_err;
  int          n_run = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  swallow_divider dut (
    .clk(clk), .rst(rst), .p_sel(p_sel), .a_in(a_in), .b_in(b_in),
    .fb_pulse(fb_pulse), .cfg_err(cfg_err)
  );

  // columns: sel, A, B, expected N, expected error flag
  localparam int NV = 12;
  localparam int VEC [NV][5] = '{
    '{0,  0,   3,   24, 0},   // R3
    '{0,  5,   3,   27, 1},   // R4
    '{0,  7,  10,   87, 0},
    '{1,  1,   3,   49, 0},
    '{1, 16,  20,  336, 0},
    '{2,  0,   4,  128, 0},   // R3
    '{2, 31,  40, 1311, 0},
    '{3, 63,  63, 4095, 0},
    '{3,  2,   3,  194, 0},
    '{0,  0,   1,   24, 1},   // R5
    '{1,  0,   0,   48, 1},   // R5
    '{0, 63, 100,  863, 0}
  };

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(int s, int a, int b);
    p_sel = 2'(s); a_in = 6'(a); b_in = 13'(b);
  endtask

  // counts negedge samples until fb_pulse is seen high
  task automatic wait_pulse(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!fb_pulse && cnt < 100000);
  endtask

  task automatic do_reset(int s, int a, int b);
    set_cfg(s, a, b);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R8 out low in reset", int'(fb_pulse), 0);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c;
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i][0], VEC[i][1], VEC[i][2]);
      // now at cycle 1 sample
      chk("R8 out low cycle 1", int'(fb_pulse), 0);
      chk("R4/R5 cfg_err", int'(cfg_err), VEC[i][4]);
      wait_pulse(c);
      chk("R8 first pulse cycle", c + 1, VEC[i][3]);
      @(negedge clk);
      chk("R7 pulse width", int'(fb_pulse), 0);
      wait_pulse(c);
      chk("R1 R2 R3 period", c + 1, VEC[i][3]);
    end

    // mid-cycle change: R6
    do_reset(0, 0, 3);
    wait_pulse(c);
    repeat (3) @(negedge clk);
    set_cfg(1, 5, 10);
    wait_pulse(c);
    chk("R6 old period kept", c, 21);
    wait_pulse(c);
    chk("R6 new period", c, 165);
    repeat (2) @(negedge clk);
    set_cfg(0, 9, 4);
    chk("R6 flag unchanged mid-cycle", int'(cfg_err), 0);
    wait_pulse(c);
    chk("R6 remaining count", c, 163);
    @(negedge clk);
    chk("R4 flag after load", int'(cfg_err), 1);
    wait_pulse(c);
    chk("R4 clamped period", c + 1, 36);
    set_cfg(2, 3, 5);
    @(negedge clk);
    chk("R4 flag clears", int'(cfg_err), 0);
    wait_pulse(c);
    chk("R2 sel 2 period", c + 1, 163);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule